// File: doc/BRIEF.md
# Peripheral Read Response Parser

This block sits behind the receive FIFO of a display serial link host. After a bus turnaround, the peripheral sends back a short burst of 32-bit words. Control logic hands the parser the number of words waiting and the largest number of bytes the requester wants. The parser then pops exactly that many words from the FIFO. The FIFO presents its head word on `rd_data_i`, and one pop moves it to the next word.

The first word is a trigger status word. It may be an acknowledge, an escape trigger, or some other value, which is flagged as unknown. The second word, when present, is the response header. Its data type selects how the rest is handled:
- An error report is latched as a 16-bit field.
- A one- or two-byte short read is sent out as bytes.
- A long read yields a byte count, and the words after it are unpacked into a byte stream, lowest byte first.

The byte stream is cut at the smaller of the caller's limit and the announced length. Results stay on the outputs until the next response is accepted.

Top module: `rsp_parser`

## Requirements
- R1: A start is accepted only while the block is idle and `word_cnt_i` is non-zero. A start with a zero count pops no word, raises neither `busy_o` nor `done_o`, and leaves every result output unchanged.
- R2: An accepted response pops exactly `word_cnt_i` words, one `rd_pop_o` cycle per word. A start raised while busy is ignored.
- R3: The first word is compared in full: 0x00000084 sets `stat_ack_o`, 0x00000087 sets `stat_esc_o`, and any other value sets `stat_unknown_o`. Exactly one of the three is set after each response.
- R4: `rsp_type_o` shows bits 5:0 of the second word (the header). It is 0 when the response has a single word.
- R5: Header type 0x02 sets `err_valid_o` and puts header bits 23:8 on `err_report_o`, and no bytes are sent. The error bits mean: 15 protocol violation, 14 reserved, 13 bad length, 12 bad virtual channel, 11 unrecognised data type, 10 checksum, 9 multi-bit ECC, 8 single-bit ECC, 7 contention, 6 false control, 5 peripheral timeout, 4 low-power transmit sync, 3 escape entry, 2 end-of-transmission sync, 1 start-of-transmission sync, 0 start-of-transmission.
- R6: Header type 0x21 sends the byte in header bits 15:8. Header type 0x22 sends bits 15:8 and then bits 23:16. In both cases the number of bytes sent is capped at `max_len_i`.
- R7: Header types 0x1A and 0x1C put header bits 23:8 on `long_len_o`. The following words are sent out as bytes, with byte k of a word taken from bits 8k+7:8k. The number of bytes is the smallest of that length, `max_len_i`, and 4 × (`word_cnt_i` − 2).
- R8: Any other header type sets `type_unknown_o`. It sends no bytes, and the remaining words are still popped.
- R9: Status flags, type, error report and length hold their values from the end of one response until the next accepted start, which clears them.
- R10: After reset the block is idle with every output low. Each accepted response ends with a single `done_o` cycle, and the block is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin parsing a response |
| word_cnt_i | input | 5 | Words waiting in the FIFO |
| max_len_i | input | 16 | Largest byte count the requester accepts |
| rd_data_i | input | 32 | FIFO head word |
| rd_pop_o | output | 1 | Consume the head word |
| busy_o | output | 1 | Response in progress |
| done_o | output | 1 | One-cycle end-of-response pulse |
| stat_ack_o | output | 1 | Status word was an acknowledge |
| stat_esc_o | output | 1 | Status word was an escape trigger |
| stat_unknown_o | output | 1 | Status word not recognised |
| rsp_type_o | output | 6 | Header data type |
| type_unknown_o | output | 1 | Header data type not handled |
| err_valid_o | output | 1 | Error report latched |
| err_report_o | output | 16 | Error report bits |
| long_len_o | output | 16 | Announced long-response length |
| byte_valid_o | output | 1 | `byte_o` carries a payload byte |
| byte_o | output | 8 | Payload byte |

## Verification
The bench builds the block with its default parameters: a 5-bit word count and a 16-bit length. It sweeps these together:
- seven header types, including two unhandled codes;
- word counts from one to six;
- five byte limits from 0 to 16;
- four announced lengths from 0 to 40;
- all three kinds of status word.

This range reaches every way the byte stream can be cut short: by the caller's limit, by the announced length, and by running out of words. It also covers a response that ends after the status word. Zero-count starts and starts raised while busy are included.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_LANES = WORD_W / 8;
  localparam int LANE_W     = $clog2(BYTE_LANES);
  localparam int LANE_CNT_W = LANE_W + 1;

  localparam logic [5:0] DT_ACK_ERR    = 6'h02;
  localparam logic [5:0] DT_GEN_LONG   = 6'h1A;
  localparam logic [5:0] DT_DCS_LONG   = 6'h1C;
  localparam logic [5:0] DT_DCS_SHORT1 = 6'h21;
  localparam logic [5:0] DT_DCS_SHORT2 = 6'h22;

  localparam logic [WORD_W-1:0] ST_ACK = 32'h0000_0084;
  localparam logic [WORD_W-1:0] ST_ESC = 32'h0000_0087;

  typedef enum logic [2:0] {K_ERR, K_SHORT1, K_SHORT2, K_LONG, K_UNKNOWN} rsp_kind_e;
  typedef enum logic [2:0] {S_IDLE, S_STAT, S_HDR, S_LOAD, S_EMIT, S_DONE} ps_state_e;
endpackage

// File: rtl/rsp_classify.sv
module rsp_classify
  import rsp_pkg::*;
(
  input  logic [WORD_W-1:0] hdr_i,
  output logic [5:0]        dtype_o,
  output rsp_kind_e         kind_o,
  output logic [15:0]       field_o
);
  always_comb begin
    dtype_o = hdr_i[5:0];
    field_o = hdr_i[23:8];
    case (hdr_i[5:0])
      DT_ACK_ERR:               kind_o = K_ERR;
      DT_DCS_SHORT1:            kind_o = K_SHORT1;
      DT_DCS_SHORT2:            kind_o = K_SHORT2;
      DT_GEN_LONG, DT_DCS_LONG: kind_o = K_LONG;
      default:                  kind_o = K_UNKNOWN;
    endcase
  end
endmodule

// File: rtl/rsp_status_decode.sv
module rsp_status_decode
  import rsp_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic              ack_o,
  output logic              esc_o,
  output logic              unk_o
);
  assign ack_o = (word_i == ST_ACK);
  assign esc_o = (word_i == ST_ESC);
  assign unk_o = !ack_o && !esc_o;
endmodule

// File: rtl/rsp_byte_emit.sv
module rsp_byte_emit
  import rsp_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  limit_set_i,
  input  logic [LEN_W-1:0]      limit_i,
  input  logic                  load_i,
  input  logic [WORD_W-1:0]     word_i,
  input  logic [LANE_CNT_W-1:0] lanes_i,
  input  logic                  step_i,
  output logic                  byte_valid_o,
  output logic [7:0]            byte_o,
  output logic                  last_lane_o
);
  logic [WORD_W-1:0]     shreg_q;
  logic [LANE_W-1:0]     lane_q;
  logic [LANE_CNT_W-1:0] nlanes_q;
  logic [LEN_W-1:0]      emitted_q, limit_q;

  assign byte_o       = shreg_q[{lane_q, 3'b000} +: 8];
  assign byte_valid_o = step_i && (emitted_q < limit_q);
  assign last_lane_o  = (({1'b0, lane_q}) + 1'b1) == nlanes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q   <= '0;
      lane_q    <= '0;
      nlanes_q  <= '0;
      emitted_q <= '0;
      limit_q   <= '0;
    end else begin
      if (clear_i) begin
        emitted_q <= '0;
        limit_q   <= '0;
      end else if (limit_set_i) begin
        limit_q <= limit_i;
      end
      if (load_i) begin
        shreg_q  <= word_i;
        lane_q   <= '0;
        nlanes_q <= lanes_i;
      end else if (step_i) begin
        lane_q <= lane_q + 1'b1;
        if (byte_valid_o) emitted_q <= emitted_q + 1'b1;
      end
    end
  end

  // R7: byte output never passes the programmed limit
  a_r7_emit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emitted_q <= limit_q);
endmodule

// File: rtl/rsp_parser.sv
module rsp_parser
  import rsp_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int LEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic [31:0]       rd_data_i,
  output logic              rd_pop_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              stat_ack_o,
  output logic              stat_esc_o,
  output logic              stat_unknown_o,
  output logic [5:0]        rsp_type_o,
  output logic              type_unknown_o,
  output logic              err_valid_o,
  output logic [15:0]       err_report_o,
  output logic [15:0]       long_len_o,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o
);
  localparam int CMP_W = (LEN_W > 16) ? LEN_W : 16;

  ps_state_e             state_q, state_d;
  logic [CNT_W-1:0]      words_q;
  logic [LEN_W-1:0]      max_q;
  logic                  accept;
  logic                  st_ack, st_esc, st_unk;
  logic [5:0]            dtype;
  rsp_kind_e             kind;
  logic [15:0]           field;
  logic                  is_short;
  logic                  emit_load, emit_step, last_lane;
  logic [WORD_W-1:0]     emit_word;
  logic [LANE_CNT_W-1:0] emit_lanes;
  logic [LEN_W-1:0]      limit_val;

  function automatic logic [LEN_W-1:0] clip(input logic [CMP_W-1:0] want,
                                            input logic [CMP_W-1:0] cap);
    clip = LEN_W'((want < cap) ? want : cap);
  endfunction

  rsp_status_decode u_stat (
    .word_i (rd_data_i),
    .ack_o  (st_ack),
    .esc_o  (st_esc),
    .unk_o  (st_unk)
  );

  rsp_classify u_cls (
    .hdr_i   (rd_data_i),
    .dtype_o (dtype),
    .kind_o  (kind),
    .field_o (field)
  );

  assign is_short = (kind == K_SHORT1) || (kind == K_SHORT2);
  assign accept   = (state_q == S_IDLE) && start_i && (word_cnt_i != '0);
  assign rd_pop_o = (state_q == S_STAT) || (state_q == S_HDR) || (state_q == S_LOAD);
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);

  always_comb begin
    emit_load  = (state_q == S_LOAD) || ((state_q == S_HDR) && is_short);
    emit_step  = (state_q == S_EMIT);
    emit_word  = (state_q == S_LOAD) ? rd_data_i : {8'h00, rd_data_i[WORD_W-1:8]};
    emit_lanes = (state_q == S_LOAD) ? LANE_CNT_W'(BYTE_LANES)
               : (kind == K_SHORT2) ? LANE_CNT_W'(2) : LANE_CNT_W'(1);
    case (kind)
      K_SHORT1: limit_val = clip(CMP_W'(1), CMP_W'(max_q));
      K_SHORT2: limit_val = clip(CMP_W'(2), CMP_W'(max_q));
      K_LONG:   limit_val = clip(CMP_W'(field), CMP_W'(max_q));
      default:  limit_val = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (accept) state_d = S_STAT;
      S_STAT: state_d = (words_q == CNT_W'(1)) ? S_DONE : S_HDR;
      S_HDR:  state_d = is_short ? S_EMIT : (words_q > CNT_W'(1)) ? S_LOAD : S_DONE;
      S_LOAD: state_d = S_EMIT;
      S_EMIT: if (last_lane) state_d = (words_q != '0) ? S_LOAD : S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  rsp_byte_emit #(.LEN_W(LEN_W)) u_emit (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (accept),
    .limit_set_i  (state_q == S_HDR),
    .limit_i      (limit_val),
    .load_i       (emit_load),
    .word_i       (emit_word),
    .lanes_i      (emit_lanes),
    .step_i       (emit_step),
    .byte_valid_o (byte_valid_o),
    .byte_o       (byte_o),
    .last_lane_o  (last_lane)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= S_IDLE;
      words_q        <= '0;
      max_q          <= '0;
      stat_ack_o     <= 1'b0;
      stat_esc_o     <= 1'b0;
      stat_unknown_o <= 1'b0;
      rsp_type_o     <= '0;
      type_unknown_o <= 1'b0;
      err_valid_o    <= 1'b0;
      err_report_o   <= '0;
      long_len_o     <= '0;
    end else begin
      state_q <= state_d;
      if (rd_pop_o) words_q <= words_q - 1'b1;
      case (state_q)
        S_IDLE: if (accept) begin
          words_q        <= word_cnt_i;
          max_q          <= max_len_i;
          stat_ack_o     <= 1'b0;
          stat_esc_o     <= 1'b0;
          stat_unknown_o <= 1'b0;
          rsp_type_o     <= '0;
          type_unknown_o <= 1'b0;
          err_valid_o    <= 1'b0;
          err_report_o   <= '0;
          long_len_o     <= '0;
        end
        S_STAT: begin
          stat_ack_o     <= st_ack;
          stat_esc_o     <= st_esc;
          stat_unknown_o <= st_unk;
        end
        S_HDR: begin
          rsp_type_o     <= dtype;
          type_unknown_o <= (kind == K_UNKNOWN);
          if (kind == K_ERR) begin
            err_valid_o  <= 1'b1;
            err_report_o <= field;
          end
          if (kind == K_LONG) long_len_o <= field;
        end
        default: ;
      endcase
    end
  end

  // R2: every pop is backed by a counted word
  a_r2_pop_has_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_o |-> (words_q != '0));
  // R1: zero-count start leaves the block idle
  a_r1_zero_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (word_cnt_i == '0)) |=> !busy_o);
  // R3: at most one status classification
  a_r3_status_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stat_ack_o, stat_esc_o, stat_unknown_o}));
  // R5: error report excludes a long length
  a_r5_err_no_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> (long_len_o == '0) && !type_unknown_o);
  // R8: unknown type sends no bytes
  a_r8_unknown_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    type_unknown_o |-> !byte_valid_o);
  // R9: results hold while idle without a start
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(err_report_o) && $stable(err_valid_o) && $stable(long_len_o)));
  // R10: done is followed by idle
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: tb/sim_rsp_parser.sv
module sim_rsp_parser;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  cnt_i = '0;
  logic [15:0] max_i = '0;
  logic [31:0] mem [0:31];
  logic [4:0]  rptr;
  logic        rptr_clr = 1'b0;
  logic        mon_clr = 1'b0;
  logic [31:0] rd_data;
  logic        rd_pop_o, busy_o, done_o, stat_ack_o, stat_esc_o, stat_unknown_o;
  logic [5:0]  rsp_type_o;
  logic        type_unknown_o, err_valid_o, byte_valid_o;
  logic [15:0] err_report_o, long_len_o;
  logic [7:0]  byte_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] got [0:63];
  int nb = 0, npop = 0, ndone = 0;

  assign rd_data = mem[rptr];

  rsp_parser u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .word_cnt_i(cnt_i),
    .max_len_i(max_i), .rd_data_i(rd_data), .rd_pop_o(rd_pop_o), .busy_o(busy_o),
    .done_o(done_o), .stat_ack_o(stat_ack_o), .stat_esc_o(stat_esc_o),
    .stat_unknown_o(stat_unknown_o), .rsp_type_o(rsp_type_o),
    .type_unknown_o(type_unknown_o), .err_valid_o(err_valid_o),
    .err_report_o(err_report_o), .long_len_o(long_len_o),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o)
  );

  always @(posedge clk) begin
    if (rptr_clr) rptr <= '0;
    else if (rd_pop_o) rptr <= rptr + 1'b1;
  end

  always @(negedge clk) begin
    if (mon_clr) begin
      nb = 0; npop = 0; ndone = 0;
    end else begin
      if (byte_valid_o && nb < 64) begin got[nb] = byte_o; nb++; end
      if (rd_pop_o) npop++;
      if (done_o) ndone++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic prep();
    @(posedge clk); #1;
    rptr_clr = 1'b1; mon_clr = 1'b1;
    @(posedge clk); #1;
    rptr_clr = 1'b0; mon_clr = 1'b0;
  endtask

  task automatic run_case(input logic [31:0] status, input logic [5:0] dtype,
                          input logic [15:0] fld, input int cnt, input int maxl,
                          input logic [7:0] seed);
    int exp_n;
    bit known, is_long, mism;
    logic [47:0] snap;
    mem[0] = status;
    mem[1] = {8'hA5, fld[15:8], fld[7:0], 2'b01, dtype};
    for (int w = 2; w < 32; w++)
      for (int k = 0; k < 4; k++)
        mem[w][8*k +: 8] = 8'(int'(seed) + 4*(w-2) + k);
    prep();
    start_i = 1'b1; cnt_i = 5'(cnt); max_i = 16'(maxl);
    @(posedge clk); #1;
    cnt_i = 5'd31;              // start while busy: must be ignored (R2)
    @(posedge clk); #1;
    start_i = 1'b0;
    for (int i = 0; i < 400 && ndone == 0; i++) @(negedge clk);
    @(negedge clk);
    is_long = (dtype == 6'h1A) || (dtype == 6'h1C);
    known = is_long || dtype == 6'h02 || dtype == 6'h21 || dtype == 6'h22;
    check("R2", "pops", 32'(npop), 32'(cnt));
    check("R10", "done pulses", 32'(ndone), 32'd1);
    check("R10", "idle after done", {31'd0, busy_o}, 32'd0);
    check("R3", "status flags", {29'd0, stat_ack_o, stat_esc_o, stat_unknown_o},
          {29'd0, status == 32'h84, status == 32'h87, status != 32'h84 && status != 32'h87});
    check("R4", "type", {26'd0, rsp_type_o}, (cnt >= 2) ? {26'd0, dtype} : 32'd0);
    check("R8", "unknown type", {31'd0, type_unknown_o}, {31'd0, cnt >= 2 && !known});
    check("R5", "error report", {15'd0, err_valid_o, err_report_o},
          (cnt >= 2 && dtype == 6'h02) ? {15'd0, 1'b1, fld} : 32'd0);
    check("R7", "long length", {16'd0, long_len_o}, (cnt >= 2 && is_long) ? {16'd0, fld} : 32'd0);
    exp_n = 0;
    if (cnt >= 2) begin
      if (dtype == 6'h21) exp_n = imin(1, maxl);
      else if (dtype == 6'h22) exp_n = imin(2, maxl);
      else if (is_long) exp_n = imin(imin(int'(fld), maxl), 4*(cnt-2));
    end
    if (is_long) check("R7", "byte count", 32'(nb), 32'(exp_n));
    else check("R6", "byte count", 32'(nb), 32'(exp_n));
    mism = 0;
    for (int j = 0; j < exp_n && j < nb; j++) begin
      logic [7:0] e;
      e = is_long ? 8'(int'(seed) + j) : ((j == 0) ? fld[7:0] : fld[15:8]);
      if (got[j] !== e) begin
        mism = 1;
        $display("FAIL %s byte %0d: actual=%0h expected=%0h", is_long ? "R7" : "R6", j, got[j], e);
      end
    end
    checks++;
    if (mism) errors++;
    snap = {err_report_o, long_len_o, rsp_type_o, stat_ack_o, stat_esc_o, stat_unknown_o,
            type_unknown_o, err_valid_o, 5'd0};
    repeat (3) @(negedge clk);
    check("R9", "hold while idle", 32'({err_report_o, long_len_o} ^ snap[47:16]), 32'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R10 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [5:0]  types [0:6];
    int          lens  [0:3];
    int          maxes [0:4];
    logic [31:0] stats [0:2];
    logic [15:0] fld, keep_err;
    int iter;
    types = '{6'h02, 6'h21, 6'h22, 6'h1A, 6'h1C, 6'h05, 6'h3F};
    lens  = '{0, 3, 7, 40};
    maxes = '{0, 1, 3, 5, 16};
    stats = '{32'h84, 32'h87, 32'h184};
    for (int i = 0; i < 32; i++) mem[i] = '0;
    rptr = '0;
    repeat (3) @(negedge clk);
    check("R10", "reset outputs",
          {16'd0, busy_o, done_o, rd_pop_o, byte_valid_o, stat_ack_o, stat_esc_o,
           stat_unknown_o, type_unknown_o, err_valid_o, 7'd0}, 32'd0);
    check("R10", "reset values", {err_report_o, long_len_o}, 32'd0);
    rst_ni = 1'b1;
    iter = 0;
    for (int t = 0; t < 7; t++)
      for (int c = 1; c <= 6; c++)
        for (int m = 0; m < 5; m++)
          for (int f = 0; f < 4; f++) begin
            if (types[t] == 6'h1A || types[t] == 6'h1C) fld = 16'(lens[f]);
            else fld = (16'h0001 << ((t*7 + c + f) % 16)) | (16'h0100 << f) | 16'(m);
            run_case(stats[iter % 3], types[t], fld, c, maxes[m], 8'(t*31 + c*5 + f));
            iter++;
          end
    // R1: zero-count start after an error report
    run_case(32'h84, 6'h02, 16'hA5C3, 3, 4, 8'h10);
    keep_err = err_report_o;
    prep();
    start_i = 1'b1; cnt_i = 5'd0; max_i = 16'd8;
    @(posedge clk); #1;
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "zero-count pops", 32'(npop), 32'd0);
    check("R1", "zero-count busy/done", {30'd0, busy_o, 1'(ndone != 0)}, 32'd0);
    check("R1", "zero-count keeps report", {16'd0, err_report_o}, {16'd0, keep_err});
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule